// File: doc/BRIEF.md
# Paged Program Counter

This block holds the instruction fetch address of a small 8-bit microcontroller core. The address is 13 bits wide. Its low byte can be read by software and it can be loaded in several ways. The upper five bits cannot be read at all. They are loaded only from a separate 5-bit page latch, and only when the low byte is loaded. A decoder drives one strobe per action:
- sequential increment;
- direct write of the low byte;
- computed jump, which adds an offset to the low byte;
- absolute branch with an 11-bit literal;
- load of a full 13-bit value popped from the return stack.

On a low-byte write or a computed jump, all five latch bits supply the upper address. On an absolute branch, only the two top latch bits supply the page, and the literal supplies the rest. A computed jump never carries into the upper bits. The block also offers the next sequential address, which the core pushes on a call. A pop loads the stored address as it is, and the latch is left alone.

Top module: `pc_pager`

## Requirements
- R1: After reset, `fetch_addr` and `latch_q` are both zero.
- R2: With `inc_en` high and no load strobe, `fetch_addr` advances by one on the next clock, wrapping from 0x1FFF to 0x0000.
- R3: `pc_lo` always equals bits 7:0 of `fetch_addr`.
- R4: A low-byte write (`lo_wr`) sets `fetch_addr` to {latch bits 4:0, `lo_wdata`}.
- R5: An absolute branch (`br_en`, used for both call and goto) sets `fetch_addr` to {latch bits 4:3, `br_lit[10:0]`}.
- R6: A computed jump (`add_en`) sets the low byte to (current low byte + `add_off`) mod 256. The upper five bits come from latch bits 4:0, and the carry out of the low byte is dropped.
- R7: A pop (`pop_en`) sets `fetch_addr` to `pop_data` in full. The latch keeps its value unless `latch_wr` is also high.
- R8: `latch_wr` loads `latch_wdata` into the latch, which is seen on `latch_q` the next cycle. A latch write alone does not change `fetch_addr`.
- R9: `push_addr` always equals (`fetch_addr` + 1) mod 8192.
- R10: When several strobes are high in one cycle, exactly one action is taken. The order of precedence is pop, then branch, then computed jump, then low-byte write, then increment.
- R11: When `latch_wr` coincides with a load, the load uses the latch value held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_en | input | 1 | Sequential increment request |
| lo_wr | input | 1 | Low-byte write strobe |
| lo_wdata | input | 8 | Data for the low-byte write |
| add_en | input | 1 | Computed jump strobe |
| add_off | input | 8 | Offset added to the low byte |
| br_en | input | 1 | Absolute branch (call or goto) strobe |
| br_lit | input | 11 | Branch literal from the opcode |
| pop_en | input | 1 | Load from the return stack |
| pop_data | input | 13 | Address popped from the stack |
| latch_wr | input | 1 | Page latch write strobe |
| latch_wdata | input | 5 | Data for the page latch |
| fetch_addr | output | 13 | Current fetch address |
| pc_lo | output | 8 | Readable low byte of the address |
| latch_q | output | 5 | Page latch contents |
| push_addr | output | 13 | Next sequential address, offered for push |

## Verification
Two kinds of collision matter.
- A load strobe can fall in the same cycle as the increment strobe, or as another load strobe. This is where the order of precedence decides the result.
- A latch write can coincide with a load that reads the latch. Here the old latch value must be used.

The bench raises each strobe independently at random, so these collisions occur often. It also places directed collisions: a pop together with a branch, and a latch write together with a low-byte write. A behavioural model settles each collision by the stated order and compares the outcome on every clock.

// File: rtl/pc_pager.sv
module pc_pager #(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int LIT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic              lo_wr,
  input  logic [LO_W-1:0]   lo_wdata,
  input  logic              add_en,
  input  logic [LO_W-1:0]   add_off,
  input  logic              br_en,
  input  logic [LIT_W-1:0]  br_lit,
  input  logic              pop_en,
  input  logic [PC_W-1:0]   pop_data,
  input  logic              latch_wr,
  input  logic [PC_W-LO_W-1:0] latch_wdata,
  output logic [PC_W-1:0]   fetch_addr,
  output logic [LO_W-1:0]   pc_lo,
  output logic [PC_W-LO_W-1:0] latch_q,
  output logic [PC_W-1:0]   push_addr
);
  localparam int HI_W = PC_W - LO_W;
  localparam int PG_W = PC_W - LIT_W;
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic [PC_W-1:0] pc_q, pc_d;
  logic [HI_W-1:0] lat_q;
  logic [LO_W-1:0] sum_lo;

  assign sum_lo = pc_q[LO_W-1:0] + add_off;

  always_comb begin
    if (pop_en)      pc_d = pop_data;
    else if (br_en)  pc_d = {lat_q[HI_W-1 -: PG_W], br_lit};
    else if (add_en) pc_d = {lat_q, sum_lo};
    else if (lo_wr)  pc_d = {lat_q, lo_wdata};
    else if (inc_en) pc_d = pc_q + ONE;
    else             pc_d = pc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      lat_q <= '0;
    end else begin
      pc_q <= pc_d;
      if (latch_wr) lat_q <= latch_wdata;
    end
  end

  assign fetch_addr = pc_q;
  assign pc_lo      = pc_q[LO_W-1:0];
  assign latch_q    = lat_q;
  assign push_addr  = pc_q + ONE;

  assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !lo_wr && !add_en && !br_en && !pop_en)
      |=> fetch_addr == $past(fetch_addr) + ONE);

  assert_lo_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !add_en && !br_en && !pop_en)
      |=> fetch_addr == {$past(latch_q), $past(lo_wdata)});

  assert_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_en && !pop_en)
      |=> fetch_addr == {$past(latch_q[HI_W-1 -: PG_W]), $past(br_lit)});

  assert_add_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !br_en && !pop_en)
      |=> fetch_addr[PC_W-1:LO_W] == $past(latch_q));

  assert_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> fetch_addr == $past(pop_data));

  assert_pop_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !latch_wr) |=> $stable(latch_q));

  assert_latch_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_wr && !inc_en && !lo_wr && !add_en && !br_en && !pop_en)
      |=> ($stable(fetch_addr) && latch_q == $past(latch_wdata)));
endmodule

// File: tb/pc_pager_test.sv
module pc_pager_test;
  logic clk = 0;
  logic rst_n = 0;
  logic inc_en = 0, lo_wr = 0, add_en = 0, br_en = 0, pop_en = 0, latch_wr = 0;
  logic [7:0]  lo_wdata = 0, add_off = 0;
  logic [10:0] br_lit = 0;
  logic [12:0] pop_data = 0;
  logic [4:0]  latch_wdata = 0;
  logic [12:0] fetch_addr, push_addr;
  logic [7:0]  pc_lo;
  logic [4:0]  latch_q;

  int checks = 0, errors = 0, cyc = 0;
  int m_pc = 0, m_lat = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pc_pager uut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    inc_en = 0; lo_wr = 0; add_en = 0; br_en = 0; pop_en = 0; latch_wr = 0;
  endtask

  task automatic step();
    string tag;
    int nload;
    nload = int'(pop_en) + int'(br_en) + int'(add_en) + int'(lo_wr) + int'(inc_en);
    tag = "R8";
    if (pop_en) begin m_pc = pop_data; tag = "R7"; end
    else if (br_en) begin m_pc = ((m_lat >> 3) << 11) | br_lit; tag = "R5"; end
    else if (add_en) begin m_pc = (m_lat << 8) | (((m_pc & 255) + add_off) & 255); tag = "R6"; end
    else if (lo_wr) begin m_pc = (m_lat << 8) | lo_wdata; tag = "R4"; end
    else if (inc_en) begin m_pc = (m_pc + 1) % 8192; tag = "R2"; end
    if (nload > 1) tag = "R10";
    if (latch_wr && nload > 0 && !inc_en) tag = "R11";
    if (latch_wr) m_lat = latch_wdata;
    @(posedge clk);
    @(negedge clk);
    clear_in();
    chk({tag, " fetch_addr"}, fetch_addr, m_pc);
    chk("R3 pc_lo", pc_lo, m_pc & 255);
    chk("R8 latch_q", latch_q, m_lat);
    chk("R9 push_addr", push_addr, (m_pc + 1) % 8192);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R1 reset fetch_addr", fetch_addr, 0);
    chk("R1 reset latch_q", latch_q, 0);
    // wrap
    pop_en = 1; pop_data = 13'h1FFF; step();
    inc_en = 1; step();
    chk("R2 wrap to zero", fetch_addr, 0);
    // computed jump with dropped carry
    latch_wr = 1; latch_wdata = 5'h0A; step();
    pop_en = 1; pop_data = 13'h12F0; step();
    add_en = 1; add_off = 8'h20; step();
    chk("R6 no carry", fetch_addr, 13'h0A10);
    // branch page bits
    latch_wr = 1; latch_wdata = 5'h1B; step();
    br_en = 1; br_lit = 11'h5A5; inc_en = 1; step();
    chk("R5 branch page", fetch_addr, 13'h1DA5);
    // pop over branch
    pop_en = 1; pop_data = 13'h0777; br_en = 1; step();
    chk("R10 pop wins", fetch_addr, 13'h0777);
    // latch write coincident with low write
    lo_wr = 1; lo_wdata = 8'h3C; latch_wr = 1; latch_wdata = 5'h04; step();
    chk("R11 old latch used", fetch_addr, 13'h1B3C);
    chk("R11 new latch stored", latch_q, 5'h04);
    // random
    for (int i = 0; i < 4000; i++) begin
      inc_en   = ($urandom_range(0, 3) != 0);
      lo_wr    = ($urandom_range(0, 7) == 0);
      add_en   = ($urandom_range(0, 7) == 0);
      br_en    = ($urandom_range(0, 7) == 0);
      pop_en   = ($urandom_range(0, 9) == 0);
      latch_wr = ($urandom_range(0, 4) == 0);
      lo_wdata = 8'($urandom);
      add_off  = 8'($urandom);
      br_lit   = 11'($urandom);
      pop_data = 13'($urandom);
      latch_wdata = 5'($urandom);
      step();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 100000 && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule